// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Pinned Slots

This block is a small, fully associative data translation buffer that holds two kinds of entries in one searchable array. Pinned entries sit in a fixed section that purges never disturb. Cached entries sit in a replaceable section that a local purge may clear. Software-style commands arrive on one synchronous command port. An insert places an entry at an explicit slot in the chosen section. A purge removes cached translations for a region, an address and a page size. A key query returns the protection key of the matching translation, or a miss code. A promote query evaluates the privilege-promotion rule used when an instruction enters privileged code.

Every command takes one cycle. The block registers the result and pulses a done strobe with it on the cycle after the command is accepted. A lookup compares the region identifier together with the implemented virtual-address bits above the entry's own page size. It considers only entries that are both valid and present.

Top module: `region_tlb`

## Requirements
- R1: An insert (op 0) with the pinned flag set writes pinned slot `cmdSlot`. With the flag clear it writes cached slot `cmdSlot`. A slot number at or beyond the chosen section's count (8 pinned, 16 cached) leaves every entry unchanged.
- R2: An insert into a slot that already holds a valid entry replaces that entry completely.
- R3: Entry fields are taken from two words. In `cmdPte0`, bit 0 is present, bits 3:2 are the privilege level and bits 6:4 are the access rights. In `cmdPte1`, bits 5:0 hold the log2 page size and bits 31:8 hold the 24-bit key. A lookup hits an entry only when the entry is valid and present, its region matches, and `cmdVa[47:ps]` equals the stored address bits.
- R4: A key query (op 2) that hits returns the key in bits 31:8 of `keyResult`, with all other bits zero. When several entries hit, pinned entries win over cached ones, and a lower slot wins over a higher one.
- R5: A key query returns exactly 1 on a miss, when the hit entry is not present, or when any of `cmdVa[63:48]` is set.
- R6: A purge (op 1) with a size from 12 to 28 invalidates every cached entry that has the same region and whose page overlaps the purge range. Two ranges overlap when their address bits above the larger of the two page sizes are equal.
- R7: A purge with a size outside 12 to 28 invalidates every cached entry.
- R8: A purge never changes any pinned entry.
- R9: A promote query (op 3) returns the hit entry's privilege level only when the entry's rights equal 7 (execute-only) and its level is numerically smaller than `cmdCurPl`. In every other case, including a miss, it returns `cmdCurPl`.
- R10: `doneValid` is high for exactly the cycle after each accepted command. The result of that command is visible in the same cycle.
- R11: Reset invalidates all entries and clears `doneValid`, `keyResult` and `newPl` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command accepted this cycle |
| cmdOp | input | 2 | 0 insert, 1 purge, 2 key query, 3 promote query |
| cmdSlot | input | 4 | Target slot for an insert |
| cmdPinned | input | 1 | Insert into the pinned section |
| cmdPte0 | input | 64 | First translation word (present, level, rights) |
| cmdPte1 | input | 64 | Second translation word (page size, key) |
| cmdVa | input | 64 | Virtual address |
| cmdRid | input | 24 | Region identifier |
| cmdPs | input | 6 | Log2 purge size |
| cmdCurPl | input | 2 | Current privilege level for promote |
| doneValid | output | 1 | Command completed |
| keyResult | output | 64 | Key query result |
| newPl | output | 2 | Promote query result |

## Verification
Several properties are checked by assertions on every cycle. A command always produces exactly one done pulse. Purges leave the pinned valid bits untouched. An unsupported purge size empties the cached section. A promote result never exceeds the current level. Every key result is either 1 or a key placed in bits 31:8.

Other behaviours need the bench's scenarios, which compare results against an arithmetic model. These are which entry wins when several match, partial overlap between pages of different sizes, overwrite of an occupied slot, and the silent drop of an out-of-range slot.

// File: rtl/region_tlb_pkg.sv
package region_tlb_pkg;
  localparam int KEY_W = 24;
  localparam int PL_W  = 2;
  localparam int PS_W  = 6;
  localparam logic [2:0] RIGHTS_XO = 3'd7;

  typedef enum logic [1:0] {
    OP_INSERT  = 2'd0,
    OP_PURGE   = 2'd1,
    OP_KEY     = 2'd2,
    OP_PROMOTE = 2'd3
  } tlbOp_e;

  typedef struct packed {
    logic doInsert;
    logic doPurge;
    logic doKey;
    logic doPromote;
    logic pinned;
    logic purgeAll;
  } tlbStrobe_t;
endpackage

// File: rtl/region_tlb_ctrl.sv
module region_tlb_ctrl
  import region_tlb_pkg::*;
#(
  parameter int PS_MIN = 12,
  parameter int PS_MAX = 28
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic            cmdPinned,
  input  logic [PS_W-1:0] cmdPs,
  output tlbStrobe_t      strobe,
  output logic            doneValid
);
  localparam logic [PS_W-1:0] PS_LO = PS_W'(PS_MIN);
  localparam logic [PS_W-1:0] PS_HI = PS_W'(PS_MAX);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      strobe.doInsert  = (cmdOp == OP_INSERT);
      strobe.doPurge   = (cmdOp == OP_PURGE);
      strobe.doKey     = (cmdOp == OP_KEY);
      strobe.doPromote = (cmdOp == OP_PROMOTE);
    end
    strobe.pinned   = strobe.doInsert && cmdPinned;
    strobe.purgeAll = strobe.doPurge && ((cmdPs < PS_LO) || (cmdPs > PS_HI));
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneValid <= 1'b0;
    else       doneValid <= cmdValid;
  end

  // R10: one done pulse per command, none without
  assert_done_after_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> doneValid);
  assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !doneValid);
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doInsert, strobe.doPurge, strobe.doKey, strobe.doPromote}));
endmodule

// File: rtl/region_tlb_data.sv
module region_tlb_data
  import region_tlb_pkg::*;
#(
  parameter int TR_SLOTS  = 8,
  parameter int TC_SLOTS  = 16,
  parameter int RID_W     = 24,
  parameter int IMPL_VA_W = 48,
  parameter int SLOT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic [63:0]      cmdPte0,
  input  logic [63:0]      cmdPte1,
  input  logic [63:0]      cmdVa,
  input  logic [RID_W-1:0] cmdRid,
  input  logic [PS_W-1:0]  cmdPs,
  input  logic [PL_W-1:0]  cmdCurPl,
  output logic [63:0]      keyResult,
  output logic [PL_W-1:0]  newPl
);
  localparam int N     = TR_SLOTS + TC_SLOTS;
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]           entValid;
  logic                   entPres   [N];
  logic [RID_W-1:0]       entRid    [N];
  logic [IMPL_VA_W-1:0]   entVa     [N];
  logic [PS_W-1:0]        entPs     [N];
  logic [KEY_W-1:0]       entKey    [N];
  logic [PL_W-1:0]        entPl     [N];
  logic [2:0]             entRights [N];

  logic                   vaImpl;
  logic [IMPL_VA_W-1:0]   vaLow;
  logic [N-1:0]           hitVec;
  logic [TC_SLOTS-1:0]    purgeHit;
  logic [IDX_W-1:0]       selIdx;
  logic                   hit;
  logic                   wrOk;
  logic [IDX_W-1:0]       wrIdx;
  logic                   unusedBits;

  assign unusedBits = ^{cmdPte0[63:7], cmdPte0[1], cmdPte1[63:32], cmdPte1[7:6]};
  assign vaImpl = ~|cmdVa[63:IMPL_VA_W];
  assign vaLow  = cmdVa[IMPL_VA_W-1:0];

  for (genvar g = 0; g < N; g++) begin : gLookup
    logic [IMPL_VA_W-1:0] lkMask;
    assign lkMask    = {IMPL_VA_W{1'b1}} << entPs[g];
    assign hitVec[g] = entValid[g] && entPres[g] && (entRid[g] == cmdRid)
                       && (((vaLow ^ entVa[g]) & lkMask) == '0);
  end

  for (genvar t = 0; t < TC_SLOTS; t++) begin : gPurge
    logic [PS_W-1:0]      widePs;
    logic [IMPL_VA_W-1:0] pgMask;
    assign widePs      = (entPs[TR_SLOTS+t] > cmdPs) ? entPs[TR_SLOTS+t] : cmdPs;
    assign pgMask      = {IMPL_VA_W{1'b1}} << widePs;
    assign purgeHit[t] = entValid[TR_SLOTS+t] && (entRid[TR_SLOTS+t] == cmdRid)
                         && (((vaLow ^ entVa[TR_SLOTS+t]) & pgMask) == '0);
  end

  always_comb begin
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end
  assign hit = vaImpl && (|hitVec);

  always_comb begin
    wrOk  = 1'b0;
    wrIdx = '0;
    if (strobe.pinned) begin
      if (int'(cmdSlot) < TR_SLOTS) begin
        wrOk  = 1'b1;
        wrIdx = IDX_W'(cmdSlot);
      end
    end else if (int'(cmdSlot) < TC_SLOTS) begin
      wrOk  = 1'b1;
      wrIdx = IDX_W'(int'(cmdSlot) + TR_SLOTS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
    end else if (strobe.doInsert && wrOk) begin
      entValid[wrIdx] <= 1'b1;
    end else if (strobe.doPurge) begin
      for (int t = 0; t < TC_SLOTS; t++) begin
        if (strobe.purgeAll || purgeHit[t]) entValid[TR_SLOTS+t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doInsert && wrOk) begin
      entPres[wrIdx]   <= cmdPte0[0];
      entPl[wrIdx]     <= cmdPte0[3:2];
      entRights[wrIdx] <= cmdPte0[6:4];
      entPs[wrIdx]     <= cmdPte1[5:0];
      entKey[wrIdx]    <= cmdPte1[31:8];
      entRid[wrIdx]    <= cmdRid;
      entVa[wrIdx]     <= vaLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyResult <= '0;
      newPl     <= '0;
    end else begin
      if (strobe.doKey)
        keyResult <= hit ? {32'b0, entKey[selIdx], 8'b0} : 64'd1;
      if (strobe.doPromote)
        newPl <= (hit && entRights[selIdx] == RIGHTS_XO && entPl[selIdx] < cmdCurPl)
                 ? entPl[selIdx] : cmdCurPl;
    end
  end

  // R8: pinned section untouched by purge
  assert_pinned_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPurge |=> entValid[TR_SLOTS-1:0] == $past(entValid[TR_SLOTS-1:0]));
  // R7: unsupported size empties the cached section
  assert_overpurge_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.purgeAll |=> entValid[N-1:TR_SLOTS] == '0);
  // R9: promotion never raises the level number
  assert_promote_no_raise_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doPromote |=> newPl <= $past(cmdCurPl));
  // R4: result shape
  assert_key_shape_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doKey |=> (keyResult == 64'd1) || (keyResult[63:32] == '0 && keyResult[7:0] == '0));
  // R5: unimplemented address misses
  assert_unimpl_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doKey && !vaImpl) |=> keyResult == 64'd1);
endmodule

// File: rtl/region_tlb.sv
module region_tlb
  import region_tlb_pkg::*;
#(
  parameter  int TR_SLOTS  = 8,
  parameter  int TC_SLOTS  = 16,
  parameter  int RID_W     = 24,
  parameter  int IMPL_VA_W = 48,
  parameter  int PS_MIN    = 12,
  parameter  int PS_MAX    = 28,
  localparam int SLOT_W    = $clog2((TC_SLOTS > TR_SLOTS) ? TC_SLOTS : TR_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              cmdPinned,
  input  logic [63:0]       cmdPte0,
  input  logic [63:0]       cmdPte1,
  input  logic [63:0]       cmdVa,
  input  logic [RID_W-1:0]  cmdRid,
  input  logic [5:0]        cmdPs,
  input  logic [1:0]        cmdCurPl,
  output logic              doneValid,
  output logic [63:0]       keyResult,
  output logic [1:0]        newPl
);
  tlbStrobe_t strobe;

  region_tlb_ctrl #(.PS_MIN(PS_MIN), .PS_MAX(PS_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPinned(cmdPinned), .cmdPs(cmdPs), .strobe(strobe), .doneValid(doneValid)
  );

  region_tlb_data #(
    .TR_SLOTS(TR_SLOTS), .TC_SLOTS(TC_SLOTS), .RID_W(RID_W),
    .IMPL_VA_W(IMPL_VA_W), .SLOT_W(SLOT_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdSlot(cmdSlot),
    .cmdPte0(cmdPte0), .cmdPte1(cmdPte1), .cmdVa(cmdVa), .cmdRid(cmdRid),
    .cmdPs(cmdPs), .cmdCurPl(cmdCurPl), .keyResult(keyResult), .newPl(newPl)
  );
endmodule

// File: tb/region_tlb_tb_top.sv
module region_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTR = 8;
  localparam int NTC = 16;
  localparam int NE  = NTR + NTC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [3:0] cmdSlot = '0;
  logic cmdPinned = 1'b0;
  logic [63:0] cmdPte0 = '0, cmdPte1 = '0, cmdVa = '0;
  logic [23:0] cmdRid = '0;
  logic [5:0] cmdPs = '0;
  logic [1:0] cmdCurPl = '0;
  logic doneValid;
  logic [63:0] keyResult;
  logic [1:0] newPl;

  int total = 0;
  int bad = 0;

  // bench model of the entries
  logic        mV [NE];
  logic        mP [NE];
  logic [23:0] mRid [NE];
  logic [47:0] mVa [NE];
  int          mPs [NE];
  logic [23:0] mKey [NE];
  logic [1:0]  mPl [NE];
  logic [2:0]  mRt [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  region_tlb dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSlot(cmdSlot),
    .cmdPinned(cmdPinned), .cmdPte0(cmdPte0), .cmdPte1(cmdPte1), .cmdVa(cmdVa),
    .cmdRid(cmdRid), .cmdPs(cmdPs), .cmdCurPl(cmdCurPl),
    .doneValid(doneValid), .keyResult(keyResult), .newPl(newPl)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int matchIdx(input logic [63:0] va, input logic [23:0] rid);
    if (va[63:48] != 0) return -1;
    for (int i = 0; i < NE; i++)
      if (mV[i] && mP[i] && mRid[i] == rid && ((va[47:0] ^ mVa[i]) >> mPs[i]) == 0) return i;
    return -1;
  endfunction

  // drive at negedge, hold one cycle, result sampled at the following negedge
  task automatic issue(input logic [1:0] op);
    cmdOp = op;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(64'(doneValid), 64'd1, "R10 done");
  endtask

  task automatic insert(input logic pin, input int slot, input logic [63:0] va, input logic [23:0] rid,
                        input int ps, input logic [23:0] key, input logic [1:0] pl,
                        input logic [2:0] rt, input logic pres);
    int idx;
    cmdPinned = pin; cmdSlot = 4'(slot); cmdVa = va; cmdRid = rid;
    cmdPte0 = {57'b0, rt, pl, 1'b0, pres};
    cmdPte1 = {32'b0, key, 2'b0, 6'(ps)};
    issue(2'd0);
    idx = pin ? ((slot < NTR) ? slot : -1) : ((slot < NTC) ? NTR + slot : -1);
    if (idx >= 0) begin
      mV[idx] = 1'b1; mP[idx] = pres; mRid[idx] = rid; mVa[idx] = va[47:0];
      mPs[idx] = ps; mKey[idx] = key; mPl[idx] = pl; mRt[idx] = rt;
    end
  endtask

  task automatic keyCheck(input logic [63:0] va, input logic [23:0] rid, input string req);
    int idx;
    cmdVa = va; cmdRid = rid;
    issue(2'd2);
    idx = matchIdx(va, rid);
    check(keyResult, (idx < 0) ? 64'd1 : {32'b0, mKey[idx], 8'b0}, req);
  endtask

  task automatic plCheck(input logic [63:0] va, input logic [23:0] rid, input logic [1:0] cur,
                         input string req);
    int idx;
    logic [1:0] exp;
    cmdVa = va; cmdRid = rid; cmdCurPl = cur;
    issue(2'd3);
    idx = matchIdx(va, rid);
    exp = cur;
    if (idx >= 0 && mRt[idx] == 3'd7 && mPl[idx] < cur) exp = mPl[idx];
    check(64'(newPl), 64'(exp), req);
  endtask

  task automatic purge(input logic [63:0] va, input logic [23:0] rid, input int ps);
    cmdVa = va; cmdRid = rid; cmdPs = 6'(ps);
    issue(2'd1);
    for (int t = NTR; t < NE; t++) begin
      int w;
      w = (mPs[t] > ps) ? mPs[t] : ps;
      if (ps < 12 || ps > 28) mV[t] = 1'b0;
      else if (mV[t] && mRid[t] == rid && ((va[47:0] ^ mVa[t]) >> w) == 0) mV[t] = 1'b0;
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NE; i++) keyCheck({16'b0, mVa[i]} | 64'h8, mRid[i], req);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin
      mV[i] = 0; mP[i] = 0; mRid[i] = 24'(i); mVa[i] = 48'(i) << 30; mPs[i] = 12;
      mKey[i] = 0; mPl[i] = 0; mRt[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check({61'b0, doneValid, newPl}, 64'd0, "R11 outputs after reset");
    check(keyResult, 64'd0, "R11 key after reset");
    rstN = 1'b1;
    @(negedge clk);
    check(64'(doneValid), 64'd0, "R10 idle no done");
    keyCheck(64'h0000_0000_1000_0010, 24'd5, "R11 empty miss");

    // R3/R4 hand-computed hit
    insert(1'b1, 0, 64'h0000_0000_1000_0000, 24'd5, 12, 24'hABCDE, 2'd0, 3'd0, 1'b1);
    cmdVa = 64'h0000_0000_1000_0ABC; cmdRid = 24'd5; issue(2'd2);
    check(keyResult, 64'h0000_0000_0ABC_DE00, "R4 pinned hit key");
    keyCheck(64'h0000_0000_1000_1000, 24'd5, "R3 next page miss");
    keyCheck(64'h0000_0000_1000_0010, 24'd6, "R3 wrong region miss");
    cmdVa = 64'h0001_0000_1000_0010; issue(2'd2);
    check(keyResult, 64'd1, "R5 unimplemented address");

    // R1/R3 fill cached section with every page size
    for (int i = 0; i < NTC; i++)
      insert(1'b0, i, (64'(i + 1) << 28) | 64'h12_3000, 24'(i % 3), 12 + i,
             24'h100 + 24'(i * 'h1111), 2'(i), 3'(i), (i != 5));
    sweep("R3 cached sweep");
    for (int i = 0; i < NTC; i++) begin
      keyCheck({16'b0, mVa[NTR+i]} + (64'd1 << mPs[NTR+i]), mRid[NTR+i], "R3 past page end");
      keyCheck({16'b0, mVa[NTR+i]} | (64'd1 << 52), mRid[NTR+i], "R5 unimplemented sweep");
    end
    keyCheck({16'b0, mVa[NTR+5]}, mRid[NTR+5], "R5 not present");

    // R4 priority: pinned slot 1 shadows cached slot 2
    insert(1'b1, 1, {16'b0, mVa[NTR+2]}, mRid[NTR+2], 12, 24'h77777, 2'd1, 3'd7, 1'b1);
    cmdVa = {16'b0, mVa[NTR+2]}; cmdRid = mRid[NTR+2]; issue(2'd2);
    check(keyResult, 64'h0000_0000_0777_7700, "R4 pinned wins");

    // R2 overwrite, R1 out-of-range slot
    insert(1'b0, 3, 64'h0000_0000_4012_3000, 24'd0, 16, 24'h5A5A5, 2'd0, 3'd7, 1'b1);
    keyCheck(64'h0000_0000_4012_3000, 24'd0, "R2 overwrite new key");
    insert(1'b1, 9, 64'h0000_0007_0000_0000, 24'd9, 12, 24'h33333, 2'd0, 3'd0, 1'b1);
    keyCheck(64'h0000_0007_0000_0000, 24'd9, "R1 out-of-range slot ignored");
    sweep("R1 nothing else changed");

    // R9 promotion sweep over rights, levels and current level
    for (int k = 0; k < 4; k++)
      insert(1'b1, 2 + k, 64'h0000_0000_9000_0000 + (64'(k) << 20), 24'd7, 12,
             24'h1000 + 24'(k), 2'(k), (k % 2 == 0) ? 3'd7 : 3'd3, 1'b1);
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 4; c++)
        plCheck(64'h0000_0000_9000_0000 + (64'(k) << 20), 24'd7, 2'(c), "R9 promote");
    cmdVa = 64'h0000_0000_9000_0000; cmdRid = 24'd7; cmdCurPl = 2'd3; issue(2'd3);
    check(64'(newPl), 64'd0, "R9 execute-only level 0 from 3");
    plCheck(64'h0000_0000_9000_0000, 24'd8, 2'd2, "R9 miss keeps level");

    // R6 exact, wrong region, then overlapping purges
    purge({16'b0, mVa[NTR+0]}, mRid[NTR+0], 12);
    sweep("R6 exact purge");
    purge({16'b0, mVa[NTR+1]}, mRid[NTR+1] + 24'd1, 28);
    sweep("R6 wrong region kept");
    insert(1'b0, 0, 64'h0000_000A_0000_0000, 24'd4, 12, 24'hAAA, 2'd0, 3'd0, 1'b1);
    insert(1'b0, 1, 64'h0000_000A_0800_0000, 24'd4, 13, 24'hBBB, 2'd0, 3'd0, 1'b1);
    purge(64'h0000_000A_0000_0000, 24'd4, 28);
    keyCheck(64'h0000_000A_0800_0000, 24'd4, "R6 overlap purged");
    check(keyResult, 64'd1, "R6 larger purge removes small page");
    purge({16'b0, mVa[NTR+10]} & ~48'hFFF, mRid[NTR+10], 12);
    sweep("R6 partial overlap of larger page");

    // R8 purge over a pinned page, then R7 unsupported size
    purge(64'h0000_0000_1000_0000, 24'd5, 28);
    keyCheck(64'h0000_0000_1000_0010, 24'd5, "R8 pinned survives purge");
    purge(64'h0, 24'd0, 40);
    sweep("R7 unsupported size clears cache");
    cmdVa = 64'h0000_0000_1000_0010; cmdRid = 24'd5; issue(2'd2);
    check(keyResult, 64'h0000_0000_0ABC_DE00, "R8 pinned kept after over-purge");
    @(negedge clk);
    check(64'(doneValid), 64'd0, "R10 done is a single pulse");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule